// File: doc/BRIEF.md
# Parallel Variable-Length Code Matcher

This block resolves one prefix-free variable-length symbol against a code table that lives in a wide memory. Each memory row holds `LANES` packed table entries. One read brings in a whole row. Every entry in that row is then compared at once against a 32-bit look-ahead window that was captured at start. The per-lane match flags are OR-reduced. If any flag is set, the symbol and code length are taken from the matching lane. If none is set, the search moves on to the next row. The fetch of the next row is issued speculatively while the current row is being compared, so one row is tested per clock.

The caller supplies the row address of the table, its row count and the window, then pulses `start`. Several tables may sit back to back in the memory. Each table starts on a row boundary, and the final partial row of each table is padded with zero-length entries. When `done` pulses, the caller consumes `len_out` bits of its bitstream. Advancing the bitstream is the caller's job. If the table holds no matching code, the block reports an error instead of a symbol.

The controller has three states. IDLE waits for `start`, issues the read of row 0 and moves to SCAN. SCAN compares the returned row. On a hit, or after a miss on the last row, it moves to REPORT. On a miss with rows still left, it stays in SCAN while the next read is already in flight. REPORT raises `done` for one cycle and returns to IDLE.

Top module: `vlc_row_matcher`

## Requirements
- R1: An entry is 64 bits: symbol in bits 31:0, code length in bits 39:32, and code in bits 63:40, right-aligned. It matches when its length L is between 1 and 24 and the top L bits of the window equal the low L bits of the code field, with the code's upper bits zero.
- R2: Lane j of a row is the entry at bits 64·j+63 down to 64·j. Row r of a table sits at memory row `tbl_base` + r, so entry k of a table is lane k mod LANES of row k div LANES.
- R3: The search starts at row 0 of the selected table and visits rows in ascending order. The first row with a matching lane ends it, and `sym_out` and `len_out` then carry that lane's symbol and length with `err` low.
- R4: Entries with length 0 (padding) or length above 24 never match, whatever the window.
- R5: If no entry in the table's `tbl_rows` rows matches, `done` pulses with `err` high and `sym_out` and `len_out` both 0.
- R6: If the hit is in row r, `done` is high in the cycle after the (r+1)-th rising edge that follows the edge at which `start` is accepted. After a miss over R rows, this happens after the R-th edge. Each row costs one cycle.
- R7: A search issues exactly one memory read per row visited, the first at `tbl_base`, and never reads past the row that produced the hit or past the table's last row.
- R8: `start` is ignored while `busy` is high. In IDLE without `start`, no read is issued.
- R9: After reset, `busy`, `done` and `err` are low and `sym_out` and `len_out` are 0. `done` is a single-cycle pulse.
- R10: The window, base and row count are captured when `start` is accepted. Later changes on those inputs do not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted in IDLE only) |
| window | input | 32 | Look-ahead bits; the first bitstream bit is bit 31 |
| tbl_base | input | ADDR_W | Memory row of the table's row 0 |
| tbl_rows | input | ADDR_W | Number of rows in the table (at least 1) |
| mem_rd_en | output | 1 | Row read request |
| mem_rd_addr | output | ADDR_W | Row address of the read |
| mem_rd_data | input | LANES·64 | Row data, valid the cycle after the request |
| busy | output | 1 | Search in progress (SCAN or REPORT) |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | The last result found no matching code |
| sym_out | output | 32 | Decoded symbol, held until the next result |
| len_out | output | 8 | Code length in bits, held until the next result |

## Verification
The bench sweeps every code of a two-row table whose second row is partly padding. A wrong lane slice or row order would return the wrong symbol, and a missed post-increment would show up as wrong latency or extra reads. It looks up codes that are absent from the table, so that padding or over-long entries that wrongly match would produce a false symbol instead of an error. A full 24-bit code, and one that differs from it only in the last bit, check the compare width. The bench also truncates a table to one row to confirm that the search stops at the limit. It pulses `start` and changes the window mid-search to catch a design that restarts or samples live inputs.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
    localparam int ENTRY_W = 64;
    localparam int CODE_W  = 24;
    localparam int LEN_W   = 8;
    localparam int SYM_W   = 32;
    localparam int WIN_W   = 32;

    // Packed table entry: first field occupies the most significant bits.
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic [SYM_W-1:0]  sym;
    } vlc_entry_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN   = 2'd1,
        S_REPORT = 2'd2
    } vlc_state_t;
endpackage

// File: rtl/vlc_lane_match.sv
module vlc_lane_match
    import vlc_pkg::*;
(
    input  vlc_entry_t        entry,
    input  logic [WIN_W-1:0]  window,
    output logic              hit
);
    logic [WIN_W-1:0] head;
    logic             len_ok;

    // Only lengths 1..CODE_W are legal; padding (0) and oversize never hit.
    assign len_ok = (entry.len != '0) && (entry.len <= LEN_W'(CODE_W));

    always_comb begin
        head = '0;
        if (len_ok) begin
            head = window >> (6'd32 - entry.len[5:0]);
        end
        hit = len_ok && (head == {{(WIN_W-CODE_W){1'b0}}, entry.code});
    end
endmodule

// File: rtl/vlc_lane_select.sv
module vlc_lane_select
    import vlc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] hits,
    input  vlc_entry_t       entries [LANES],
    output logic             found,
    output logic [SYM_W-1:0] sym,
    output logic [LEN_W-1:0] len
);
    assign found = |hits;

    // AND-OR select: prefix-free tables give at most one hot lane; none gives 0.
    always_comb begin
        sym = '0;
        len = '0;
        for (int j = 0; j < LANES; j++) begin
            sym = sym | ({SYM_W{hits[j]}} & entries[j].sym);
            len = len | ({LEN_W{hits[j]}} & entries[j].len);
        end
    end
endmodule

// File: rtl/vlc_row_matcher.sv
module vlc_row_matcher
    import vlc_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [WIN_W-1:0]           window,
    input  logic [ADDR_W-1:0]          tbl_base,
    input  logic [ADDR_W-1:0]          tbl_rows,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_rd_addr,
    input  logic [LANES*ENTRY_W-1:0]   mem_rd_data,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [SYM_W-1:0]           sym_out,
    output logic [LEN_W-1:0]           len_out
);
    localparam int CNT_W = ADDR_W + 1;

    vlc_state_t        state_q, state_d;
    logic [WIN_W-1:0]  win_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  rows_q;
    logic [CNT_W-1:0]  fetch_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [SYM_W-1:0]  sym_q;
    logic [LEN_W-1:0]  len_q;
    logic              err_q;

    vlc_entry_t        lanes [LANES];
    logic [LANES-1:0]  hits;
    logic              found;
    logic [SYM_W-1:0]  sel_sym;
    logic [LEN_W-1:0]  sel_len;
    logic              last_row;
    logic              more_rows;

    // Per-lane decode and compare.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lanes[j] = vlc_entry_t'(mem_rd_data[j*ENTRY_W +: ENTRY_W]);
        vlc_lane_match u_match (
            .entry  (lanes[j]),
            .window (win_q),
            .hit    (hits[j])
        );
    end

    vlc_lane_select #(.LANES(LANES)) u_select (
        .hits    (hits),
        .entries (lanes),
        .found   (found),
        .sym     (sel_sym),
        .len     (sel_len)
    );

    assign last_row  = (cmp_q == rows_q - CNT_W'(1));
    assign more_rows = (fetch_q < rows_q);

    // Next-state and read request.
    always_comb begin
        state_d     = state_q;
        mem_rd_en   = 1'b0;
        mem_rd_addr = base_q + fetch_q[ADDR_W-1:0];
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = tbl_base;
                    state_d     = S_SCAN;
                end
            end
            S_SCAN: begin
                if (found || last_row) begin
                    state_d = S_REPORT;
                end else begin
                    mem_rd_en = more_rows;
                end
            end
            S_REPORT: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            base_q  <= '0;
            rows_q  <= '0;
            fetch_q <= '0;
            cmp_q   <= '0;
            sym_q   <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        win_q   <= window;
                        base_q  <= tbl_base;
                        rows_q  <= {1'b0, tbl_rows};
                        fetch_q <= CNT_W'(1);
                        cmp_q   <= '0;
                    end
                end
                S_SCAN: begin
                    cmp_q <= cmp_q + CNT_W'(1);
                    if (mem_rd_en) begin
                        fetch_q <= fetch_q + CNT_W'(1);
                    end
                    if (found) begin
                        sym_q <= sel_sym;
                        len_q <= sel_len;
                        err_q <= 1'b0;
                    end else if (last_row) begin
                        sym_q <= '0;
                        len_q <= '0;
                        err_q <= 1'b1;
                    end
                end
                S_REPORT: begin
                end
            endcase
        end
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = (state_q == S_REPORT);
    assign err     = err_q;
    assign sym_out = sym_q;
    assign len_out = len_q;
endmodule

// File: rtl/vlc_row_matcher_chk.sv
module vlc_row_matcher_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [31:0]       sym_out,
    input logic [7:0]        len_out,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [ADDR_W-1:0] tbl_base,
    input logic [ADDR_W-1:0] tbl_rows
);
    logic [ADDR_W:0] cap_base;
    logic [ADDR_W:0] cap_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_base <= '0;
            cap_end  <= '0;
        end else if (start && !busy) begin
            cap_base <= {1'b0, tbl_base};
            cap_end  <= {1'b0, tbl_base} + {1'b0, tbl_rows};
        end
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (sym_out == '0 && len_out == '0));

    assert_hit_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (len_out != '0 && len_out <= 8'd24));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |-> !mem_rd_en);

    assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (mem_rd_en && mem_rd_addr == tbl_base));

    assert_rd_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rd_en) |-> ({1'b0, mem_rd_addr} >= cap_base &&
                                 {1'b0, mem_rd_addr} < cap_end));

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind vlc_row_matcher vlc_row_matcher_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .sym_out     (sym_out),
    .len_out     (len_out),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .tbl_base    (tbl_base),
    .tbl_rows    (tbl_rows)
);

// File: tb/vlc_row_matcher_tb_top.sv
module vlc_row_matcher_tb_top;
    localparam int LANES  = 8;
    localparam int ADDR_W = 6;
    localparam int NROWS  = 64;
    localparam int ROW_W  = LANES * 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       window = '0;
    logic [ADDR_W-1:0] tbl_base = '0;
    logic [ADDR_W-1:0] tbl_rows = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [ROW_W-1:0]  mem_rd_data = '0;
    logic              busy, done, err;
    logic [31:0]       sym_out;
    logic [7:0]        len_out;

    logic [ROW_W-1:0]  mem [NROWS];
    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    int bad_rd = 0;
    int cur_lo = 0;
    int cur_hi = 0;

    always #4 clk = ~clk;  // 125 MHz

    vlc_row_matcher #(.LANES(LANES), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .window(window),
        .tbl_base(tbl_base), .tbl_rows(tbl_rows),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .err(err), .sym_out(sym_out), .len_out(len_out)
    );

    // One-cycle-latency row memory and read monitor.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr];
            rd_cnt <= rd_cnt + 1;
            if (int'(mem_rd_addr) < cur_lo || int'(mem_rd_addr) >= cur_hi) bad_rd <= bad_rd + 1;
        end
    end

    task automatic report_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        report_end();
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int base, input int idx, input logic [23:0] code,
                       input logic [7:0] len, input logic [31:0] sym);
        mem[base + idx / LANES][(idx % LANES)*64 +: 64] = {code, len, sym};
    endtask

    // Independent linear reference search (R1, R2, R4).
    task automatic ref_search(input int base, input int rows, input logic [31:0] w,
                              output bit found, output int row,
                              output logic [31:0] sym, output logic [7:0] len);
        found = 0; row = 0; sym = '0; len = '0;
        for (int k = 0; k < rows * LANES; k++) begin
            logic [63:0] e;
            int l;
            e = mem[base + k / LANES][(k % LANES)*64 +: 64];
            l = int'(e[39:32]);
            if (!found && l >= 1 && l <= 24) begin
                if ((w >> (32 - l)) == {8'd0, e[63:40]}) begin
                    found = 1; row = k / LANES; sym = e[31:0]; len = e[39:32];
                end
            end
        end
    endtask

    // Run one search; optionally disturb inputs mid-search (R8, R10).
    task automatic run(input string req, input int base, input int rows,
                       input logic [31:0] w, input bit disturb);
        bit f; int row; logic [31:0] es; logic [7:0] el;
        int n, exp_n;
        ref_search(base, rows, w, f, row, es, el);
        exp_n = f ? row + 1 : rows;
        @(negedge clk);
        tbl_base = ADDR_W'(base); tbl_rows = ADDR_W'(rows); window = w;
        cur_lo = base; cur_hi = base + rows; rd_cnt = 0; bad_rd = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            if (disturb) begin
                start = 1'b1; window = ~w; tbl_base = '0; tbl_rows = ADDR_W'(2);
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk(done == 1'b1, req, "done seen", longint'(done), 1);
        chk(err == !f, f ? req : "R5", "err", longint'(err), longint'(!f));
        chk(sym_out == es, f ? req : "R5", "sym_out", longint'(sym_out), longint'(es));
        chk(len_out == el, f ? req : "R5", "len_out", longint'(len_out), longint'(el));
        chk(n == exp_n, "R6", "done latency", longint'(n), longint'(exp_n));
        chk(rd_cnt == exp_n, "R7", "read count", longint'(rd_cnt), longint'(exp_n));
        chk(bad_rd == 0, "R7", "reads outside table", longint'(bad_rd), 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done single pulse", longint'(done), 0);
        if (disturb) chk(sym_out == es, "R8", "result after disturbed start", longint'(sym_out), longint'(es));
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R9", "reset flags", longint'({busy, done, err}), 0);
        chk(sym_out == '0 && len_out == '0, "R9", "reset result", longint'({sym_out, len_out}), 0);
        chk(!mem_rd_en, "R8", "no read in idle", longint'(mem_rd_en), 0);
    endtask

    // Sweep every code of table A: row 0 and padded row 1 (R1, R2, R3).
    task automatic t_sweep_a();
        logic [23:0] codes [13] = '{24'b111, 24'b010, 24'b000, 24'b1101, 24'b1010,
                                    24'b1000, 24'b0111, 24'b0010, 24'b1011, 24'b0110,
                                    24'b11001, 24'b00110, 24'b10011};
        int lens [13] = '{3, 3, 3, 4, 4, 4, 4, 4, 4, 4, 5, 5, 5};
        for (int k = 0; k < 13; k++) begin
            logic [31:0] w;
            w = (32'(codes[k]) << (32 - lens[k])) | (32'h5A5A5A5A >> lens[k]);
            run(k < 8 ? "R3" : "R2", 0, 2, w, 0);
        end
    endtask

    task automatic t_padding();
        run("R4", 0, 2, 32'hC000_0000, 0);    // 11000: absent, padding must not hit
        run("R4", 16, 1, 32'h0000_0000, 0);   // only an oversize entry present
    endtask

    task automatic t_short_table();
        run("R7", 0, 1, 32'hB000_0000, 0);    // 1011 lives in row 1, excluded
    endtask

    task automatic t_long_codes();
        run("R1", 8, 3, 32'hABCD_EF12, 0);    // 24-bit code, row 2 lane 7
        run("R1", 8, 3, 32'hABCD_EE00, 0);    // last bit differs: miss
        run("R3", 8, 3, 32'h1234_5678, 0);    // 1-bit code, row 2 lane 0
    endtask

    task automatic t_disturb();
        run("R10", 8, 3, 32'hABCD_EF12, 1);
    endtask

    initial begin
        for (int r = 0; r < NROWS; r++) mem[r] = '0;
        // Table A at row 0: 13 entries + 3 zero padding entries.
        put(0, 0, 24'b111, 3, 32'h20);   put(0, 1, 24'b010, 3, 32'h61);
        put(0, 2, 24'b000, 3, 32'h65);   put(0, 3, 24'b1101, 4, 32'h66);
        put(0, 4, 24'b1010, 4, 32'h74);  put(0, 5, 24'b1000, 4, 32'h68);
        put(0, 6, 24'b0111, 4, 32'h69);  put(0, 7, 24'b0010, 4, 32'h73);
        put(0, 8, 24'b1011, 4, 32'h6C);  put(0, 9, 24'b0110, 4, 32'h6D);
        put(0, 10, 24'b11001, 5, 32'h6E); put(0, 11, 24'b00110, 5, 32'h6F);
        put(0, 12, 24'b10011, 5, 32'h70);
        // Table B at row 8: rows 0-1 all padding, codes only in row 2.
        put(8, 16, 24'b0, 1, 32'hCAFE_0001);
        put(8, 23, 24'hABCDEF, 24, 32'hDEAD_BEEF);
        // Table C at row 16: one oversize entry only.
        put(16, 0, 24'h0, 25, 32'h1111_2222);

        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sweep_a();
        t_padding();
        t_short_table();
        t_long_codes();
        t_disturb();
        report_end();
    end
endmodule